// File: doc/BRIEF.md
# Registered Multi-Function 16-bit ALU

This block is a clocked arithmetic-logic unit for 16-bit data. On every rising clock edge it captures two operands and a 3-bit function code into input registers. It then computes one of eight functions from the captured values: add, subtract, pass-through, AND, OR, a small left shift, a truncated multiply, or a constant zero. The 16-bit result and a carry flag are loaded into output registers on the following rising edge.

The datapath is split into three units. A ripple-carry adder serves both addition and subtraction; for subtraction it inverts the second operand and forces the carry-in high. A staged shifter moves the first operand left by up to three places. A row-by-row array multiplier takes full 16-bit operands and keeps only the low half of the product. A single select stage, driven by an enumerated function code, chooses which unit's output reaches the output register.

There is no state machine. The control path is the registered function code, and each of its eight values is decoded in one `unique case`.

Top module: `alu16_reg`

## Requirements
- R1: While `rst` is high on a rising edge, every input and output register is cleared, so `result` reads 0x0000 and `carry_out` reads 0 after that edge.
- R2: `result` and `carry_out` reflect the operands and function code presented before the rising edge two edges earlier: capture happens on the first edge and the result is loaded on the second.
- R3: Function code 3'b001 copies operand A unchanged to `result`.
- R4: Function code 3'b000 gives A+B in `result`, and `carry_out` is bit 16 of the 17-bit sum.
- R5: Function code 3'b011 gives A-B modulo 2^16 in `result`, and `carry_out` is 1 exactly when no borrow occurs (A >= B as unsigned). For example, 1-1 gives 0 with carry 1.
- R6: Function code 3'b110 gives the bitwise AND of A and B, and function code 3'b010 gives their bitwise OR.
- R7: Function code 3'b100 shifts A left by B[1:0] places (0 to 3) and fills with zeros. Bits B[15:2] have no effect.
- R8: Function code 3'b101 gives the low 16 bits of the unsigned 32-bit product A*B.
- R9: Function code 3'b111 gives 0x0000.
- R10: `carry_out` is 0 for every function code other than 3'b000 and 3'b011.
- R11: Adding 0x7FFF and 0x0001 gives 0x8000 with `carry_out` 0, so every result bit changes state along the full carry ripple.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B; bits [1:0] also give the shift amount |
| func_sel | input | 3 | Function code |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Registered carry or no-borrow flag |

## Verification
Every function has the same latency. A result is due after the second rising edge that follows the moment its operands and code are driven: one edge captures them and the next loads the output register. The bench drives inputs on falling edges and pushes the expected pair into a queue. On each falling edge it compares the output against the entry that is two steps old, so each check lands exactly in the cycle its result settles. After a reset the queue is emptied, and the zeroed outputs are checked before any new entry falls due.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    parameter int DATA_W  = 16;
    parameter int OP_W    = 3;
    parameter int SHAMT_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'b000,
        OP_PASS = 3'b001,
        OP_OR   = 3'b010,
        OP_SUB  = 3'b011,
        OP_SHL  = 3'b100,
        OP_MUL  = 3'b101,
        OP_AND  = 3'b110,
        OP_ZERO = 3'b111
    } op_e;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   chain;
    logic [W-1:0] y_eff;

    assign chain[0] = sub;
    assign y_eff    = sub ? ~y : y;

    for (genvar i = 0; i < W; i++) begin : g_slice
        assign sum[i]     = x[i] ^ y_eff[i] ^ chain[i];
        assign chain[i+1] = (x[i] & y_eff[i]) | (chain[i] & (x[i] ^ y_eff[i]));
    end

    assign cout = chain[W];
endmodule

// File: rtl/alu16_shl.sv
module alu16_shl #(
    parameter int W     = 16,
    parameter int AMT_W = 2
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [W-1:0] stage [0:AMT_W];

    assign stage[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? (stage[s] << STEP) : stage[s];
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] prod_lo
);
    logic [W-1:0] acc [0:W];

    assign acc[0] = '0;

    for (genvar r = 0; r < W; r++) begin : g_row
        logic [W-1:0] part;
        assign part       = y[r] ? (x << r) : '0;
        assign acc[r+1]   = acc[r] + part;
    end

    assign prod_lo = acc[W];
endmodule

// File: rtl/alu16_reg.sv
module alu16_reg
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [OP_W-1:0] func_sel,
    output logic [W-1:0]    result,
    output logic            carry_out
);
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    op_e          op_q;

    logic [W-1:0] as_sum;
    logic         as_cout;
    logic [W-1:0] shl_out;
    logic [W-1:0] mul_out;
    logic [W-1:0] res_d;
    logic         cy_d;

    // Input capture register
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= OP_ADD;
        end else begin
            a_q  <= opnd_a;
            b_q  <= opnd_b;
            op_q <= op_e'(func_sel);
        end
    end

    alu16_addsub #(.W(W)) u_addsub (
        .x    (a_q),
        .y    (b_q),
        .sub  (op_q == OP_SUB),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu16_shl #(.W(W), .AMT_W(SHAMT_W)) u_shl (
        .din  (a_q),
        .amt  (b_q[SHAMT_W-1:0]),
        .dout (shl_out)
    );

    alu16_mul #(.W(W)) u_mul (
        .x       (a_q),
        .y       (b_q),
        .prod_lo (mul_out)
    );

    // Function select
    always_comb begin
        res_d = '0;
        cy_d  = 1'b0;
        unique case (op_q)
            OP_ADD:  begin res_d = as_sum; cy_d = as_cout; end
            OP_SUB:  begin res_d = as_sum; cy_d = as_cout; end
            OP_PASS: res_d = a_q;
            OP_OR:   res_d = a_q | b_q;
            OP_AND:  res_d = a_q & b_q;
            OP_SHL:  res_d = shl_out;
            OP_MUL:  res_d = mul_out;
            OP_ZERO: res_d = '0;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            result    <= res_d;
            carry_out <= cy_d;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (result == '0 && !carry_out));

    a_r10_carry_only_arith: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> ($past(op_q) == OP_ADD || $past(op_q) == OP_SUB));

    a_r9_zero_code: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_q) == OP_ZERO) |-> (result == '0 && !carry_out));

    a_r3_pass_a: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_q) == OP_PASS) |-> (result == $past(a_q)));

    a_r5_equal_sub: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_q) == OP_SUB && $past(a_q) == $past(b_q))
            |-> (result == '0 && carry_out));
endmodule

// File: tb/tb_alu16_reg.sv
module tb_alu16_reg;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [2:0]   func_sel = '0;
    logic [W-1:0] result;
    logic         carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic         cy;
        string        tag;
    } exp_t;

    exp_t pending[$];

    alu16_reg dut (
        .clk       (clk),
        .rst       (rst),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .func_sel  (func_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [2:0] op);
        exp_t e;
        longint unsigned ua = a;
        longint unsigned ub = b;
        longint unsigned t;
        e.cy = 1'b0;
        case (op)
            3'b000: begin t = ua + ub; e.res = t[W-1:0]; e.cy = t[W]; e.tag = "R4"; end
            3'b001: begin e.res = a; e.tag = "R3"; end
            3'b010: begin e.res = a | b; e.tag = "R6"; end
            3'b011: begin t = (ua + 65536 - ub); e.res = t[W-1:0]; e.cy = (ua >= ub); e.tag = "R5"; end
            3'b100: begin t = ua << b[1:0]; e.res = t[W-1:0]; e.tag = "R7"; end
            3'b101: begin t = ua * ub; e.res = t[W-1:0]; e.tag = "R8"; end
            3'b110: begin e.res = a & b; e.tag = "R6"; end
            default: begin e.res = '0; e.tag = "R9"; end
        endcase
        return e;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp_res, input logic exp_cy);
        n_checks++;
        if (result !== exp_res || carry_out !== exp_cy) begin
            n_fail++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, result, carry_out, exp_res, exp_cy);
        end
    endtask

    // One step: check the entry two steps old (R2), then drive new inputs
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] op,
                        input string note);
        exp_t e;
        @(negedge clk);
        if (pending.size() == 2) begin
            e = pending.pop_front();
            check({e.tag, " R2 R10 ", note}, e.res, e.cy);
        end
        opnd_a   = a;
        opnd_b   = b;
        func_sel = op;
        e = model(a, b, op);
        pending.push_back(e);
    endtask

    task automatic drain();
        repeat (2) step('0, '0, 3'b111, "drain");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pending.delete();
        @(negedge clk);
        check("R1 during reset", '0, 1'b0);
        @(negedge clk);
        check("R1 held reset", '0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: result=%h carry=%b expected completion", result, carry_out);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", '0, 1'b0);
        rst = 1'b0;

        // R11 worst-case ripple
        step(16'h7FFF, 16'h0001, 3'b000, "R11 ripple");
        step(16'hFFFF, 16'h0001, 3'b000, "R4 wrap carry");
        step(16'h1234, 16'h1111, 3'b000, "R4 plain");
        step(16'h0001, 16'h0001, 3'b011, "R5 equal");
        step(16'h0000, 16'h0001, 3'b011, "R5 borrow");
        step(16'h8000, 16'h7FFF, 3'b011, "R5 no borrow");
        step(16'hBEEF, 16'hFFFF, 3'b001, "R3 pass");
        step(16'hF0F0, 16'h3C3C, 3'b110, "R6 and");
        step(16'hF0F0, 16'h0F0F, 3'b010, "R6 or");
        step(16'h8001, 16'hFFFC, 3'b100, "R7 shift 0 upper ignored");
        step(16'h8001, 16'h0001, 3'b100, "R7 shift 1");
        step(16'hC003, 16'hAAA2, 3'b100, "R7 shift 2");
        step(16'h1FFF, 16'h0003, 3'b100, "R7 shift 3");
        step(16'h0100, 16'h0100, 3'b101, "R8 overflow to zero");
        step(16'h00FF, 16'h0101, 3'b101, "R8 small");
        step(16'hFFFF, 16'hFFFF, 3'b101, "R8 max");
        step(16'hFFFF, 16'hFFFF, 3'b111, "R9 zero");
        step(16'hFFFF, 16'hFFFF, 3'b010, "R10 or no carry");
        drain();

        // Mid-run reset: pending results discarded
        step(16'hFFFF, 16'h0001, 3'b000, "pre-reset");
        do_reset();
        @(negedge clk);
        check("R1 first cycle after release", '0, 1'b0);

        for (int i = 0; i < 400; i++) begin
            step(W'($urandom), W'($urandom), 3'($urandom), "random");
        end
        drain();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule